// File: doc/BRIEF.md
# HDLC Receiver with Address Filter

This block receives one HDLC channel one bit at a time. Each input bit comes with a qualifying strobe, and cycles without the strobe are idle. The block finds the frame delimiters and deletes the zeros the transmitter inserted for transparency. It also recognises the abort pattern and checks the 16-bit frame check sequence. It delivers the frame body as bytes, with start and end markers and a status carried on the last byte.

Frames can be filtered on their first two bytes. Two programmable 16-bit references are available: a board-specific address and a broadcast address. Four enable inputs choose which reference bytes are compared. A frame that fails the filter produces no bytes and no events.

Three single-cycle event pulses let a surrounding controller count completed frames, aborted frames and checksum failures. Configuration arrives as static inputs.

Top module: `hdlc_rx_filt`

## Requirements
- R1: The pattern 01111110 (a zero, six ones, a zero) is a delimiter. Delimiters and idle delimiter runs produce no output bytes.
- R2: Two delimiters that share their middle zero (011111101111110) count as two delimiters. A body placed after the second one is received as a frame.
- R3: A single delimiter closes the frame before it and opens the frame after it, and both frames are delivered.
- R4: A zero that follows exactly five ones inside a frame is deleted from the data.
- R5: Seven ones in a row, once at least one frame bit has reached the assembler, raise `ev_abort` for one cycle. The frame gets no end marker, and reception restarts at the next delimiter.
- R6: The check runs over every frame byte: CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF, the frame check sequence sent low byte first. A good frame leaves residue 0xF0B8. Any other residue sets `st_fcs_bad` on the end byte and pulses `ev_fcs_bad`.
- R7: Bits are assembled least significant bit first. The two check bytes are never forwarded. `rx_sof` marks the first byte and `rx_eof` the last, and `ev_end` pulses together with `rx_eof`.
- R8: A frame of fewer than four bytes between delimiters produces no bytes and no events.
- R9: A frame of at least four whole bytes whose bit count is not a multiple of eight ends with `st_misalign` set on the end byte.
- R10: `addr_en[0]` compares the first frame byte with `spec_addr[7:0]`, and `addr_en[1]` compares the second byte with `spec_addr[15:8]`. `addr_en[2]` and `addr_en[3]` do the same against `bcast_addr`. A frame is accepted if every enabled byte of at least one reference matches, or if no enable is set.
- R11: A rejected frame produces no bytes and neither `ev_end` nor `ev_fcs_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Serial line bit |
| rx_bit_vld | input | 1 | Qualifies `rx_bit` in this cycle |
| spec_addr | input | 16 | Board address, first byte in [7:0] |
| bcast_addr | input | 16 | Broadcast address, first byte in [7:0] |
| addr_en | input | 4 | Byte compare enables (see R10) |
| rx_byte | output | 8 | Received byte |
| rx_vld | output | 1 | `rx_byte` valid |
| rx_sof | output | 1 | First byte of a frame |
| rx_eof | output | 1 | Last byte of a frame |
| st_fcs_bad | output | 1 | Check failure, valid with `rx_eof` |
| st_misalign | output | 1 | Bit count not a multiple of eight, valid with `rx_eof` |
| ev_end | output | 1 | Frame delivered pulse |
| ev_abort | output | 1 | Abort pulse |
| ev_fcs_bad | output | 1 | Check failure pulse |

## Verification
Frame bodies contain 0xFF, 0x7E and 0x3F. A lost stuffed zero or a falsely detected delimiter therefore shows up as a wrong byte or a wrong byte count.

Delimiters are sent in three forms: normal, shared-zero and single shared. Each form separates correct delimiter recovery from frame merging or frame loss.

A corrupted check word, a trailing partial byte, a three-byte frame and a seven-ones abort each drive exactly one of the status or discard paths. Address patterns that match only the specific reference, only the broadcast reference, or only one enabled byte tell the per-byte enables apart from a whole-word compare.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  // one bit of the reflected CCITT CRC
  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    crc_bit = (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_R : 16'h0000);
  endfunction

  // all enabled bytes of one reference equal, at least one enabled
  function automatic logic addr_hit(input logic [7:0] a0, input logic [7:0] a1,
                                    input logic [15:0] refw, input logic [1:0] en);
    addr_hit = (|en) && (!en[0] || a0 == refw[7:0]) && (!en[1] || a1 == refw[15:8]);
  endfunction
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int FLAG_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic dbit,
  output logic dvld,
  output logic flag_evt,
  output logic abort_evt
);
  localparam int STUFF_RUN = FLAG_RUN - 1;
  localparam int PIPE = FLAG_RUN + 1;
  localparam int CW = $clog2(FLAG_RUN + 1);

  logic [CW-1:0] ones_q;
  logic [PIPE-1:0] pd_q, pv_q;
  logic sync_q;

  wire at_run   = (ones_q == CW'(FLAG_RUN));
  wire is_flag  = bit_vld & ~bit_in & at_run;
  wire is_abort = bit_vld & bit_in & at_run;
  wire is_stuff = bit_vld & ~bit_in & (ones_q == CW'(STUFF_RUN));
  wire push     = bit_vld & ~is_flag & ~is_abort & ~is_stuff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      pd_q <= '0;
      pv_q <= '0;
      sync_q <= 1'b0;
      dbit <= 1'b0;
      dvld <= 1'b0;
      flag_evt <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      if (bit_vld) ones_q <= bit_in ? (at_run ? ones_q : ones_q + 1'b1) : '0;
      if (is_flag || is_abort) pv_q <= '0;
      else if (push) begin
        pd_q <= {pd_q[PIPE-2:0], bit_in};
        pv_q <= {pv_q[PIPE-2:0], 1'b1};
      end
      if (is_flag) sync_q <= 1'b1;
      else if (is_abort) sync_q <= 1'b0;
      dvld <= push & pv_q[PIPE-1] & sync_q;
      dbit <= pd_q[PIPE-1];
      flag_evt <= is_flag;
      abort_evt <= is_abort & sync_q;
    end
  end

  // R1
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dvld, flag_evt, abort_evt}));
  // R4
  stuff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_stuff |=> !dvld);
  // R5
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !dvld);
endmodule

// File: rtl/hdlc_rx_addr_filter.sv
module hdlc_rx_addr_filter (
  input  logic [7:0]  addr0,
  input  logic [7:0]  addr1,
  input  logic [15:0] spec_addr,
  input  logic [15:0] bcast_addr,
  input  logic [3:0]  addr_en,
  output logic        accept
);
  import hdlc_rx_pkg::*;
  localparam int NREF = 2;

  logic [NREF-1:0] hit;
  logic [15:0] refs [NREF];
  assign refs[0] = spec_addr;
  assign refs[1] = bcast_addr;

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    assign hit[g] = addr_hit(addr0, addr1, refs[g], addr_en[2*g+1 -: 2]);
  end

  assign accept = ~(|addr_en) | (|hit);
endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler #(
  parameter int BYTE_W = 8,
  parameter int FCS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbit,
  input  logic              dvld,
  input  logic              flag_evt,
  input  logic              abort_evt,
  input  logic              accept,
  output logic [BYTE_W-1:0] addr0,
  output logic [BYTE_W-1:0] addr1,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_vld,
  output logic              rx_sof,
  output logic              rx_eof,
  output logic              st_fcs_bad,
  output logic              st_misalign,
  output logic              ev_end,
  output logic              ev_abort,
  output logic              ev_fcs_bad
);
  import hdlc_rx_pkg::*;
  localparam int HOLD = FCS_BYTES + 1;
  localparam int NBW = $clog2(HOLD + 1);
  localparam int BCW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] hold_q [HOLD];
  logic [BCW-1:0] bitc_q;
  logic [NBW-1:0] nb_q;
  logic [15:0] crc_q;
  logic started_q, rel_q;

  wire [BYTE_W-1:0] sh_n = {dbit, sh_q[BYTE_W-1:1]};
  wire byte_done = dvld && (bitc_q == BCW'(BYTE_W - 1));
  wire crc_bad = (crc_q != CRC_RESIDUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
      bitc_q <= '0;
      nb_q <= '0;
      crc_q <= CRC_PRESET;
      started_q <= 1'b0;
      rel_q <= 1'b0;
      addr0 <= '0;
      addr1 <= '0;
      rx_byte <= '0;
      rx_vld <= 1'b0;
      rx_sof <= 1'b0;
      rx_eof <= 1'b0;
      st_fcs_bad <= 1'b0;
      st_misalign <= 1'b0;
      ev_end <= 1'b0;
      ev_abort <= 1'b0;
      ev_fcs_bad <= 1'b0;
    end else begin
      rx_vld <= 1'b0;
      rx_sof <= 1'b0;
      rx_eof <= 1'b0;
      ev_end <= 1'b0;
      ev_abort <= 1'b0;
      ev_fcs_bad <= 1'b0;
      if (dvld) begin
        sh_q <= sh_n;
        crc_q <= crc_bit(crc_q, dbit);
        bitc_q <= bitc_q + 1'b1;
        started_q <= 1'b1;
        if (byte_done) begin
          for (int i = HOLD - 1; i > 0; i--) hold_q[i] <= hold_q[i-1];
          hold_q[0] <= sh_n;
          if (nb_q == NBW'(0)) addr0 <= sh_n;
          if (nb_q == NBW'(1)) addr1 <= sh_n;
          if (nb_q == NBW'(HOLD)) begin
            rel_q <= 1'b1;
            if (accept) begin
              rx_vld <= 1'b1;
              rx_sof <= ~rel_q;
              rx_byte <= hold_q[HOLD-1];
            end
          end else begin
            nb_q <= nb_q + 1'b1;
          end
        end
      end else if (flag_evt || abort_evt) begin
        if (flag_evt && rel_q && accept) begin
          rx_vld <= 1'b1;
          rx_eof <= 1'b1;
          rx_byte <= hold_q[HOLD-1];
          st_fcs_bad <= crc_bad;
          st_misalign <= (bitc_q != '0);
          ev_end <= 1'b1;
          ev_fcs_bad <= crc_bad;
        end
        ev_abort <= abort_evt & started_q;
        bitc_q <= '0;
        nb_q <= '0;
        crc_q <= CRC_PRESET;
        started_q <= 1'b0;
        rel_q <= 1'b0;
      end
    end
  end

  // R8
  no_short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_sof && rx_eof));
  // R6
  fcs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fcs_bad |-> (ev_end && rx_eof && st_fcs_bad));
  // R5
  abort_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |-> !rx_vld);
  // R11
  reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> $past(accept));
  // R7
  end_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof || rx_eof) |-> rx_vld);
endmodule

// File: rtl/hdlc_rx_filt.sv
module hdlc_rx_filt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_bit,
  input  logic        rx_bit_vld,
  input  logic [15:0] spec_addr,
  input  logic [15:0] bcast_addr,
  input  logic [3:0]  addr_en,
  output logic [7:0]  rx_byte,
  output logic        rx_vld,
  output logic        rx_sof,
  output logic        rx_eof,
  output logic        st_fcs_bad,
  output logic        st_misalign,
  output logic        ev_end,
  output logic        ev_abort,
  output logic        ev_fcs_bad
);
  logic dbit, dvld, flag_evt, abort_evt, accept;
  logic [7:0] addr0, addr1;

  hdlc_rx_deframer #(.FLAG_RUN(6)) u_deframe (
    .clk(clk), .rst_n(rst_n), .bit_in(rx_bit), .bit_vld(rx_bit_vld),
    .dbit(dbit), .dvld(dvld), .flag_evt(flag_evt), .abort_evt(abort_evt)
  );

  hdlc_rx_addr_filter u_filter (
    .addr0(addr0), .addr1(addr1), .spec_addr(spec_addr),
    .bcast_addr(bcast_addr), .addr_en(addr_en), .accept(accept)
  );

  hdlc_rx_assembler #(.BYTE_W(8), .FCS_BYTES(2)) u_asm (
    .clk(clk), .rst_n(rst_n), .dbit(dbit), .dvld(dvld),
    .flag_evt(flag_evt), .abort_evt(abort_evt), .accept(accept),
    .addr0(addr0), .addr1(addr1), .rx_byte(rx_byte), .rx_vld(rx_vld),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .st_fcs_bad(st_fcs_bad),
    .st_misalign(st_misalign), .ev_end(ev_end), .ev_abort(ev_abort),
    .ev_fcs_bad(ev_fcs_bad)
  );
endmodule

// File: tb/tb_hdlc_rx_filt.sv
module tb_hdlc_rx_filt;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1, rx_bit_vld = 1'b0;
  logic [15:0] spec_addr = 16'hB2A1, bcast_addr = 16'hFFFF;
  logic [3:0] addr_en = 4'b0000;
  logic [7:0] rx_byte;
  logic rx_vld, rx_sof, rx_eof, st_fcs_bad, st_misalign, ev_end, ev_abort, ev_fcs_bad;

  hdlc_rx_filt dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  int ones_tx = 0;
  logic [7:0] fb [0:15];
  logic [7:0] cap_b [0:63]; logic cap_s [0:63]; logic cap_e [0:63]; int ncap = 0;
  logic [7:0] exp_b [0:63]; logic exp_s [0:63]; logic exp_e [0:63]; int nexp = 0;
  int n_end = 0, n_abort = 0, n_fcs = 0;
  logic last_fcs = 0, last_al = 0;

  always @(negedge clk) if (rst_n) begin
    if (rx_vld && ncap < 64) begin
      cap_b[ncap] = rx_byte; cap_s[ncap] = rx_sof; cap_e[ncap] = rx_eof; ncap++;
      if (rx_eof) begin last_fcs = st_fcs_bad; last_al = st_misalign; end
    end
    if (ev_end) n_end++;
    if (ev_abort) n_abort++;
    if (ev_fcs_bad) n_fcs++;
  end

  task automatic chk(input bit c, input string req, input string what, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    ncap = 0; nexp = 0; n_end = 0; n_abort = 0; n_fcs = 0; last_fcs = 0; last_al = 0;
  endtask

  task automatic put_raw(input logic b);
    @(negedge clk); rx_bit = b; rx_bit_vld = 1'b1;
    @(negedge clk); rx_bit_vld = 1'b0;
  endtask

  task automatic put_data(input logic b);
    put_raw(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin put_raw(1'b0); ones_tx = 0; end
    end else ones_tx = 0;
  endtask

  task automatic put_flag();
    put_raw(1'b0);
    repeat (6) put_raw(1'b1);
    put_raw(1'b0);
    ones_tx = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_data(v[i]);
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {8'h00, fb[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  // body plus check word, no delimiters; keep = frame expected at the output
  task automatic send_body(input int n, input logic [15:0] corrupt, input bit keep);
    logic [15:0] f = fcs_of(n) ^ corrupt;
    for (int k = 0; k < n; k++) put_byte(fb[k]);
    put_byte(f[7:0]);
    put_byte(f[15:8]);
    if (keep) for (int k = 0; k < n; k++) begin
      exp_b[nexp] = fb[k]; exp_s[nexp] = (k == 0); exp_e[nexp] = (k == n - 1); nexp++;
    end
  endtask

  task automatic settle();
    put_flag();
    repeat (8) @(negedge clk);
  endtask

  task automatic cmp_capture(input string req);
    chk(ncap == nexp, req, "byte count", ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      chk(cap_b[i] == exp_b[i], req, "byte value", cap_b[i], exp_b[i]);
      chk(cap_s[i] == exp_s[i], req, "sof marker", cap_s[i], exp_s[i]);
      chk(cap_e[i] == exp_e[i], req, "eof marker", cap_e[i], exp_e[i]);
    end
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                      input logic [7:0] d, input logic [7:0] e);
    fb[0] = a; fb[1] = b; fb[2] = c; fb[3] = d; fb[4] = e;
  endtask

  task automatic t_reset();
    chk(rx_vld == 0 && rx_sof == 0 && rx_eof == 0, "R7", "reset outputs", rx_vld, 0);
    chk(ev_end == 0 && ev_abort == 0 && ev_fcs_bad == 0, "R7", "reset events", ev_end, 0);
    clear_mon();
    repeat (3) put_flag();
    repeat (6) @(negedge clk);
    chk(ncap == 0 && n_end == 0, "R1", "idle delimiters give bytes", ncap, 0);
  endtask

  task automatic t_good();
    clear_mon();
    load(8'h03, 8'hFF, 8'h7E, 8'h3F, 8'h5A);
    put_flag(); send_body(5, 16'h0, 1); settle();
    cmp_capture("R4 R7");
    chk(n_end == 1, "R7", "ev_end count", n_end, 1);
    chk(last_fcs == 0 && n_fcs == 0, "R6", "good check word flagged", last_fcs, 0);
    chk(last_al == 0, "R9", "aligned frame flagged", last_al, 0);
  endtask

  task automatic t_bad_fcs();
    clear_mon();
    load(8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    put_flag(); send_body(4, 16'h0100, 1); settle();
    cmp_capture("R6");
    chk(last_fcs == 1, "R6", "st_fcs_bad", last_fcs, 1);
    chk(n_fcs == 1 && n_end == 1, "R6", "ev_fcs_bad count", n_fcs, 1);
  endtask

  task automatic t_shared();
    clear_mon();
    put_flag();
    load(8'hA0, 8'hA1, 8'hA2, 8'h00, 8'h00); send_body(3, 16'h0, 1);
    put_flag();
    repeat (6) put_raw(1'b1); put_raw(1'b0); ones_tx = 0;
    load(8'hB0, 8'hFE, 8'hB2, 8'hB3, 8'h00); send_body(4, 16'h0, 1);
    put_flag();
    load(8'hC0, 8'hC1, 8'h00, 8'h00, 8'h00); send_body(2, 16'h0, 1);
    settle();
    cmp_capture("R2 R3");
    chk(n_end == 3, "R2", "frames after shared-zero and single delimiters", n_end, 3);
    chk(n_fcs == 0, "R3", "check failures", n_fcs, 0);
  endtask

  task automatic t_abort();
    clear_mon();
    load(8'h01, 8'h02, 8'h03, 8'h00, 8'h00);
    put_flag();
    for (int k = 0; k < 3; k++) put_byte(fb[k]);
    repeat (8) put_raw(1'b1);
    load(8'h44, 8'h45, 8'h46, 8'h00, 8'h00);
    put_flag(); send_body(3, 16'h0, 1); settle();
    chk(n_abort == 1, "R5", "ev_abort count", n_abort, 1);
    chk(n_end == 1, "R5", "ev_end after resync", n_end, 1);
    cmp_capture("R5");
  endtask

  task automatic t_short();
    clear_mon();
    load(8'h10, 8'h20, 8'h30, 8'h00, 8'h00);
    put_flag();
    for (int k = 0; k < 3; k++) put_byte(fb[k]);
    settle();
    chk(ncap == 0, "R8", "bytes from short frame", ncap, 0);
    chk(n_end == 0 && n_fcs == 0 && n_abort == 0, "R8", "events from short frame", n_end, 0);
  endtask

  task automatic t_misalign();
    clear_mon();
    load(8'h61, 8'h62, 8'h63, 8'h64, 8'h65);
    put_flag(); send_body(5, 16'h0, 1);
    put_data(1'b1); put_data(1'b0); put_data(1'b1);
    settle();
    cmp_capture("R9");
    chk(last_al == 1, "R9", "st_misalign", last_al, 1);
  endtask

  task automatic t_filter();
    clear_mon();
    addr_en = 4'b0011;
    load(8'hA1, 8'hB2, 8'h99, 8'h00, 8'h00);
    put_flag(); send_body(3, 16'h0, 1); settle();
    cmp_capture("R10 specific match");
    clear_mon();
    load(8'hA1, 8'hB3, 8'h99, 8'h00, 8'h00);
    put_flag(); send_body(3, 16'h0040, 0); settle();
    chk(ncap == 0, "R11", "bytes from rejected frame", ncap, 0);
    chk(n_end == 0 && n_fcs == 0, "R11", "events from rejected frame", n_end + n_fcs, 0);
    clear_mon();
    addr_en = 4'b1111;
    load(8'hFF, 8'hFF, 8'h42, 8'h00, 8'h00);
    put_flag(); send_body(3, 16'h0, 1); settle();
    cmp_capture("R10 broadcast match");
    clear_mon();
    addr_en = 4'b0001;
    load(8'hA1, 8'h77, 8'h43, 8'h00, 8'h00);
    put_flag(); send_body(3, 16'h0, 1); settle();
    cmp_capture("R10 first byte only");
    clear_mon();
    addr_en = 4'b0100;
    load(8'hA1, 8'hFF, 8'h44, 8'h00, 8'h00);
    put_flag(); send_body(3, 16'h0, 0); settle();
    chk(ncap == 0 && n_end == 0, "R10", "broadcast byte mismatch accepted", ncap, 0);
    addr_en = 4'b0000;
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_bad_fcs();
    t_shared();
    t_abort();
    t_short();
    t_misalign();
    t_filter();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule